// File: doc/BRIEF.md
# Multi-Slot Accelerator Host Bridge

This block joins one synchronous host port to a row of accelerator slots. A flat host address is split into a slot number, a space code and a word offset. Every slot owns four direction-restricted spaces: a parameter bank the host only writes, a status bank the host only reads, an input buffer the host only writes and a result buffer the host only reads. The bridge turns each legal host access into a per-slot write or read strobe. It places the space code, offset and write data on a shared slot bus. Read data from the chosen slot comes back to the host after exactly one cycle.

Slot number 0 is the master socket. It holds a read-only identification word: bit k is set when slot k is built in. Bit 0 stands for the master itself and is always set. The master socket also holds a sticky direction-error flag. The host sets this flag by reading from a write-only space, and clears it with a write to the master. The set of populated slots is fixed by a parameter.

The host port has no back-pressure. An access is accepted in the cycle its enable is high. A read answers one cycle later, with a read-valid pulse. A write and a read may be issued in the same cycle; they then share the address. Slots must drive their read data combinationally in the cycle of their read strobe.

Top module: `slot_host_bridge`

## Requirements
- R1: The address is split as host_addr[15:11] = slot, [10:9] = space, [8:0] = offset. Space codes are: 00 host-write registers, 01 host-read registers, 10 host-write buffer, 11 host-read buffer. A host write to a populated slot k (1..31) in space 00 or 10 raises slot_we bit k only, in the same cycle. In that cycle slot_space, slot_ofs and slot_wdata equal the decoded fields and the host data.
- R2: A host read of a populated slot k in space 01 or 11 raises slot_re bit k only, in the same cycle. On the next cycle host_rdata equals that slot's lane of slot_rdata (bits k*32 to k*32+31) as sampled in the read cycle.
- R3: host_rvalid is high in exactly the cycles that follow a cycle with host_re high, whatever the target of the read.
- R4: A host write to space 01 or 11 raises no slot_we bit.
- R5: A host read of space 00 or 10 raises no slot_re bit and returns zero. If the slot is populated or is the master, the read sets the sticky error flag.
- R6: An access to an unpopulated slot raises no strobe. A read of such a slot returns zero and leaves the error flag unchanged.
- R7: A read of slot 0, space 01, offset 0 returns the identification word: PRESENT with bit 0 forced to 1. The default is 32'h8001_0443.
- R8: A read of slot 0, space 01, offset 1 returns the error flag in bit 0 with all other bits zero. Every other master read returns zero. Master accesses never raise a slot strobe.
- R9: A write to slot 0, space 00, offset 0 with data bit 0 set clears the error flag. If a set and a clear fall in the same cycle, the flag ends set.
- R10: After reset, host_rvalid, host_rdata and the error flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 16 | Flat host address: slot, space, offset |
| host_wdata | input | 32 | Host write data |
| host_we | input | 1 | Host write enable |
| host_re | input | 1 | Host read enable |
| host_rdata | output | 32 | Read data, one cycle after host_re |
| host_rvalid | output | 1 | Marks host_rdata valid |
| slot_we | output | 32 | Per-slot write strobe, bit 0 unused |
| slot_re | output | 32 | Per-slot read strobe, bit 0 unused |
| slot_space | output | 2 | Shared space code to slots |
| slot_ofs | output | 9 | Shared word offset to slots |
| slot_wdata | output | 32 | Shared write data to slots |
| slot_rdata | input | 1024 | Read data lanes, 32 bits per slot |

## Verification
The sticky error flag can be set and cleared in the same cycle. This happens when the host raises read and write together at slot 0, space 00, offset 0 with data bit 0 set: the read is illegal and sets the flag, while the write clears it. The bench drives this combined access on purpose. It then reads the flag back through the master register and expects it still set. It repeats the check after a clean clear, and its random traffic also issues writes and reads together at arbitrary addresses.

// File: rtl/slot_bridge_pkg.sv
package slot_bridge_pkg;
  typedef enum logic [1:0] {
    SP_PARAM_WR = 2'b00,
    SP_STAT_RD  = 2'b01,
    SP_BUF_WR   = 2'b10,
    SP_BUF_RD   = 2'b11
  } space_e;

  // bit 0 of the space code tells the direction: 1 = host may read
  function automatic logic host_can_read(input logic [1:0] sp);
    return sp[0];
  endfunction
endpackage

// File: rtl/sb_addr_decode.sv
module sb_addr_decode #(
  parameter int SLOT_W = 5,
  parameter int OFS_W = 9,
  parameter int SLOT_CNT = 32,
  parameter logic [SLOT_CNT-1:0] PRESENT = '0
) (
  input  logic [SLOT_W+2+OFS_W-1:0] addr,
  output logic [SLOT_W-1:0]         slot,
  output logic [1:0]                space,
  output logic [OFS_W-1:0]          ofs,
  output logic                      is_master,
  output logic                      slot_live
);
  assign slot      = addr[OFS_W+2 +: SLOT_W];
  assign space     = addr[OFS_W +: 2];
  assign ofs       = addr[OFS_W-1:0];
  assign is_master = (slot == '0);
  assign slot_live = !is_master && PRESENT[slot];
endmodule

// File: rtl/sb_strobe_gen.sv
module sb_strobe_gen
  import slot_bridge_pkg::*;
#(
  parameter int SLOT_W = 5,
  parameter int SLOT_CNT = 32,
  parameter logic [SLOT_CNT-1:0] PRESENT = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_we,
  input  logic                host_re,
  input  logic [SLOT_W-1:0]   slot,
  input  logic [1:0]          space,
  input  logic                slot_live,
  output logic [SLOT_CNT-1:0] slot_we,
  output logic [SLOT_CNT-1:0] slot_re
);
  logic wr_ok, rd_ok;
  assign wr_ok = host_we && !host_can_read(space);
  assign rd_ok = host_re && host_can_read(space);

  for (genvar k = 0; k < SLOT_CNT; k++) begin : g_lane
    if (k == 0 || !PRESENT[k]) begin : g_off
      assign slot_we[k] = 1'b0;
      assign slot_re[k] = 1'b0;
    end else begin : g_on
      assign slot_we[k] = wr_ok && (slot == SLOT_W'(k));
      assign slot_re[k] = rd_ok && (slot == SLOT_W'(k));
    end
  end

  AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_we)); // R1
  AST_RE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_re)); // R2
  AST_NO_WE_TO_READ_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    host_can_read(space) |-> slot_we == '0); // R4
  AST_NO_RE_TO_WRITE_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    !host_can_read(space) |-> slot_re == '0); // R5
  AST_ABSENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_live |-> (slot_we == '0 && slot_re == '0)); // R6
endmodule

// File: rtl/sb_master_regs.sv
module sb_master_regs
  import slot_bridge_pkg::*;
#(
  parameter int OFS_W = 9,
  parameter int DATA_W = 32,
  parameter int SLOT_CNT = 32,
  parameter logic [SLOT_CNT-1:0] PRESENT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic              host_re,
  input  logic              clr_bit,
  input  logic              is_master,
  input  logic              slot_live,
  input  logic [1:0]        space,
  input  logic [OFS_W-1:0]  ofs,
  output logic [DATA_W-1:0] master_rdata
);
  localparam logic [DATA_W-1:0] ID_WORD = DATA_W'(PRESENT | SLOT_CNT'(1));

  logic err_q, err_set, err_clr;

  assign err_set = host_re && !host_can_read(space) && (is_master || slot_live);
  assign err_clr = host_we && is_master && space == SP_PARAM_WR && ofs == '0 && clr_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (err_set) err_q <= 1'b1;
    else if (err_clr) err_q <= 1'b0;
  end

  always_comb begin
    master_rdata = '0;
    if (space == SP_STAT_RD) begin
      if (ofs == OFS_W'(0))      master_rdata = ID_WORD;
      else if (ofs == OFS_W'(1)) master_rdata = DATA_W'(err_q);
    end
  end

  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> err_q); // R5
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !err_set) |=> !err_q); // R9
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_clr && !err_set) |=> $stable(err_q)); // R9
endmodule

// File: rtl/sb_read_return.sv
module sb_read_return #(
  parameter int SLOT_W = 5,
  parameter int DATA_W = 32,
  parameter int SLOT_CNT = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       host_re,
  input  logic                       readable,
  input  logic                       is_master,
  input  logic                       slot_live,
  input  logic [SLOT_W-1:0]          slot,
  input  logic [DATA_W-1:0]          master_rdata,
  input  logic [SLOT_CNT*DATA_W-1:0] slot_rdata,
  output logic [DATA_W-1:0]          host_rdata,
  output logic                       host_rvalid
);
  logic [DATA_W-1:0] lanes [SLOT_CNT];
  logic [DATA_W-1:0] rd_next;

  for (genvar k = 0; k < SLOT_CNT; k++) begin : g_lane
    assign lanes[k] = slot_rdata[k*DATA_W +: DATA_W];
  end

  always_comb begin
    rd_next = '0;
    if (host_re) begin
      if (is_master)                 rd_next = master_rdata;
      else if (slot_live && readable) rd_next = lanes[slot];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rdata  <= rd_next;
      host_rvalid <= host_re;
    end
  end

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    host_re |=> host_rvalid); // R3
  AST_RVALID_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !host_re |=> !host_rvalid); // R3
  AST_ABSENT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (host_re && !is_master && !slot_live) |=> host_rdata == '0); // R6
  AST_WRONG_DIR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (host_re && !readable) |=> host_rdata == '0); // R5
endmodule

// File: rtl/slot_host_bridge.sv
module slot_host_bridge
  import slot_bridge_pkg::*;
#(
  parameter int SLOT_W = 5,
  parameter int OFS_W = 9,
  parameter int DATA_W = 32,
  parameter logic [(1<<SLOT_W)-1:0] PRESENT = 32'h8001_0442,
  localparam int SLOT_CNT = 1 << SLOT_W,
  localparam int ADDR_W = SLOT_W + 2 + OFS_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          host_addr,
  input  logic [DATA_W-1:0]          host_wdata,
  input  logic                       host_we,
  input  logic                       host_re,
  output logic [DATA_W-1:0]          host_rdata,
  output logic                       host_rvalid,
  output logic [SLOT_CNT-1:0]        slot_we,
  output logic [SLOT_CNT-1:0]        slot_re,
  output logic [1:0]                 slot_space,
  output logic [OFS_W-1:0]           slot_ofs,
  output logic [DATA_W-1:0]          slot_wdata,
  input  logic [SLOT_CNT*DATA_W-1:0] slot_rdata
);
  logic [SLOT_W-1:0] slot;
  logic [1:0]        space;
  logic [OFS_W-1:0]  ofs;
  logic              is_master, slot_live;
  logic [DATA_W-1:0] master_rdata;

  sb_addr_decode #(.SLOT_W(SLOT_W), .OFS_W(OFS_W), .SLOT_CNT(SLOT_CNT), .PRESENT(PRESENT))
    u_dec (.addr(host_addr), .slot(slot), .space(space), .ofs(ofs),
           .is_master(is_master), .slot_live(slot_live));

  sb_strobe_gen #(.SLOT_W(SLOT_W), .SLOT_CNT(SLOT_CNT), .PRESENT(PRESENT))
    u_stb (.clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
           .slot(slot), .space(space), .slot_live(slot_live),
           .slot_we(slot_we), .slot_re(slot_re));

  sb_master_regs #(.OFS_W(OFS_W), .DATA_W(DATA_W), .SLOT_CNT(SLOT_CNT), .PRESENT(PRESENT))
    u_mst (.clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
           .clr_bit(host_wdata[0]), .is_master(is_master), .slot_live(slot_live),
           .space(space), .ofs(ofs), .master_rdata(master_rdata));

  sb_read_return #(.SLOT_W(SLOT_W), .DATA_W(DATA_W), .SLOT_CNT(SLOT_CNT))
    u_ret (.clk(clk), .rst_n(rst_n), .host_re(host_re),
           .readable(host_can_read(space)), .is_master(is_master),
           .slot_live(slot_live), .slot(slot), .master_rdata(master_rdata),
           .slot_rdata(slot_rdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid));

  assign slot_space = space;
  assign slot_ofs   = ofs;
  assign slot_wdata = host_wdata;

  AST_MASTER_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    is_master |-> (slot_we == '0 && slot_re == '0)); // R8
endmodule

// File: tb/slot_host_bridge_test.sv
module slot_host_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] PRES = 32'h8001_0442;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic host_we = 1'b0, host_re = 1'b0;
  logic [31:0] host_rdata;
  logic host_rvalid;
  logic [31:0] slot_we, slot_re;
  logic [1:0] slot_space;
  logic [8:0] slot_ofs;
  logic [31:0] slot_wdata;
  logic [1023:0] slot_rdata;

  int checks = 0;
  int fails = 0;
  logic err_model = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_host_bridge #(.PRESENT(PRES)) uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_we(host_we), .host_re(host_re), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .slot_we(slot_we), .slot_re(slot_re),
    .slot_space(slot_space), .slot_ofs(slot_ofs), .slot_wdata(slot_wdata),
    .slot_rdata(slot_rdata));

  function automatic logic [31:0] lane_val(input int k, input logic [8:0] o);
    return {8'(k), 8'h5A, 7'h00, o};
  endfunction

  for (genvar k = 0; k < 32; k++) begin : g_model
    assign slot_rdata[k*32 +: 32] = lane_val(k, slot_ofs);
  end

  function automatic logic [15:0] mk(input int s, input int sp, input int o);
    return {5'(s), 2'(sp), 9'(o)};
  endfunction

  function automatic bit live(input logic [4:0] s);
    return s != 0 && PRES[s];
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // drive at negedge, check strobes before the edge, check return after it
  task automatic op(input logic we, input logic re, input logic [15:0] a,
                    input logic [31:0] wd, input string tag);
    logic [4:0] s;
    logic [1:0] sp;
    logic [8:0] o;
    logic [31:0] ewe, ere, erd;
    logic nerr;
    s = a[15:11]; sp = a[10:9]; o = a[8:0];
    ewe = (we && live(s) && !sp[0]) ? (32'd1 << s) : '0;
    ere = (re && live(s) && sp[0]) ? (32'd1 << s) : '0;
    erd = '0;
    if (re) begin
      if (s == 0) begin
        if (sp == 2'b01 && o == 9'd0) erd = PRES | 32'd1;
        else if (sp == 2'b01 && o == 9'd1) erd = {31'd0, err_model};
      end else if (live(s) && sp[0]) erd = lane_val(int'(s), o);
    end
    nerr = err_model;
    if (re && !sp[0] && (s == 0 || live(s))) nerr = 1'b1;
    else if (we && s == 0 && sp == 2'b00 && o == 9'd0 && wd[0]) nerr = 1'b0;
    host_we = we; host_re = re; host_addr = a; host_wdata = wd;
    #1;
    chk(tag, "slot_we", slot_we, ewe);
    chk(tag, "slot_re", slot_re, ere);
    if (ewe != 0 || ere != 0) begin
      chk(tag, "slot_space", 32'(slot_space), 32'(sp));
      chk(tag, "slot_ofs", 32'(slot_ofs), 32'(o));
      if (ewe != 0) chk(tag, "slot_wdata", slot_wdata, wd);
    end
    @(posedge clk);
    @(negedge clk);
    err_model = nerr;
    chk(tag, "host_rvalid", 32'(host_rvalid), 32'(re));
    if (re) chk(tag, "host_rdata", host_rdata, erd);
    host_we = 1'b0; host_re = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "host_rvalid", 32'(host_rvalid), 32'd0);
    chk("R10", "host_rdata", host_rdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    op(1'b0, 1'b0, '0, '0, "R10");
    op(1'b0, 1'b1, mk(0, 1, 1), '0, "R10");          // flag zero after reset
    op(1'b0, 1'b1, mk(0, 1, 0), '0, "R7");           // id word
    op(1'b1, 1'b0, mk(1, 0, 5), 32'hCAFE_0001, "R1");
    op(1'b1, 1'b0, mk(6, 2, 300), 32'h1234_5678, "R1");
    op(1'b1, 1'b0, mk(31, 0, 511), 32'hFFFF_0000, "R1");
    op(1'b0, 1'b1, mk(6, 1, 7), '0, "R2");
    op(1'b0, 1'b1, mk(31, 3, 511), '0, "R2");
    op(1'b0, 1'b1, mk(16, 3, 0), '0, "R2");
    op(1'b1, 1'b0, mk(1, 1, 3), 32'hAAAA_AAAA, "R4");
    op(1'b1, 1'b0, mk(10, 3, 3), 32'h5555_5555, "R4");
    op(1'b0, 1'b1, mk(1, 0, 9), '0, "R5");           // sets flag
    op(1'b0, 1'b1, mk(0, 1, 1), '0, "R8");           // reads flag = 1
    op(1'b0, 1'b1, mk(0, 1, 2), '0, "R8");           // other master reg = 0
    op(1'b1, 1'b0, mk(0, 2, 0), 32'hFFFF_FFFF, "R8"); // master buffer write, no strobes
    op(1'b1, 1'b0, mk(0, 0, 0), 32'd1, "R9");        // clear
    op(1'b0, 1'b1, mk(0, 1, 1), '0, "R9");
    op(1'b0, 1'b1, mk(2, 1, 4), '0, "R6");           // unpopulated read
    op(1'b1, 1'b0, mk(2, 0, 4), 32'h0F0F_0F0F, "R6");
    op(1'b0, 1'b1, mk(3, 0, 4), '0, "R6");           // unpopulated wrong dir: no flag
    op(1'b0, 1'b1, mk(0, 1, 1), '0, "R6");
    op(1'b0, 1'b1, mk(0, 2, 8), '0, "R5");           // master wrong dir sets flag
    op(1'b1, 1'b0, mk(0, 0, 0), 32'd1, "R9");
    op(1'b1, 1'b1, mk(0, 0, 0), 32'd1, "R9");        // set and clear together
    op(1'b0, 1'b1, mk(0, 1, 1), '0, "R9");           // flag stays set
    op(1'b1, 1'b0, mk(0, 0, 0), 32'd0, "R9");        // bit 0 clear: no effect
    op(1'b0, 1'b1, mk(0, 1, 1), '0, "R9");
    op(1'b1, 1'b0, mk(0, 0, 0), 32'd1, "R9");
    op(1'b0, 1'b1, mk(0, 1, 1), '0, "R9");
    op(1'b0, 1'b0, mk(6, 1, 1), '0, "R3");           // no read, no valid
    for (int i = 0; i < 600; i++) begin
      logic [15:0] a;
      logic [4:0] s;
      int pick;
      a = 16'($urandom);
      pick = int'($urandom_range(0, 5));
      case (pick)
        0: s = 5'd1;
        1: s = 5'd6;
        2: s = 5'd31;
        3: s = 5'd0;
        default: s = a[15:11];
      endcase
      a[15:11] = s;
      if (s == 0 && $urandom_range(0, 1) == 1) a[8:0] = 9'($urandom_range(0, 2));
      op(1'($urandom), 1'($urandom), a, $urandom, "RND");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule